// File: doc/BRIEF.md
# External-Memory Deep FIFO Controller

This block is a packet FIFO whose storage lives in external memory behind an AXI port, so its depth is set by a memory region and not by on-chip RAM. Beats arrive on a ready/valid input stream carrying a last flag. They are held in a small on-chip staging queue until a whole packet is present. Each packet is then written into a circular region of memory as one or more AXI write bursts.

Once a burst's write response arrives, a read job is queued holding the burst's address, its length and whether it closes the packet. The read side takes jobs in order and issues one read burst per job. R-channel beats go straight to the output stream with no local buffer, and output backpressure is passed back onto the R channel.

The read and write data buses are as wide as the stream data. Bursts are cut so that none crosses a 4096-byte address boundary, the end of the region, or the maximum burst length. No burst is issued unless the region has room for it. Each write burst stalls the drain of the staging queue by at least two cycles, so under continuous input the staging queue fills and input ready drops.

Top module: `extmem_fifo`

## Requirements
- R1: While reset is applied and after it is released, awvalid, wvalid, arvalid and out_valid are low and in_ready is high.
- R2: The output stream carries every accepted input beat, in order and unchanged. out_last is high exactly on the final beat of each packet. The write data on W matches the accepted input beats in order.
- R3: No write burst crosses a 4096-byte boundary, and no burst is longer than MAX_BURST beats. A packet that would cross a boundary is split there.
- R4: Every AW and AR address is aligned to DATA_W/8 bytes and lies, together with its whole burst, inside the region [REGION_BASE, REGION_BASE+REGION_BYTES). The write address wraps to REGION_BASE at the region's end.
- R5: Each AR carries the address and awlen of the oldest write burst whose B response has arrived and which has not yet been read, and is issued only after that response.
- R6: Once awvalid, wvalid, arvalid or out_valid is raised, it stays high with stable address, length, data and last until its handshake.
- R7: wlast is high exactly on beat awlen+1 of each write burst.
- R8: At the moment any write burst is issued, the beats written but not yet delivered on the output, plus the new burst, never exceed REGION_BYTES/(DATA_W/8).
- R9: Between the last W beat of one burst and the first W beat of the next there are at least two cycles with no W transfer.
- R10: out_valid follows rvalid, and rready follows out_ready, in the same cycle while read data is presented.
- R11: With the write path blocked, the block accepts exactly STAGE_DEPTH input beats and then holds in_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat data |
| in_last | input | 1 | Final beat of the input packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | DATA_W | Output beat data |
| out_last | output | 1 | Final beat of the output packet |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address accepted |
| awaddr | output | ADDR_W | Write burst byte address |
| awlen | output | 8 | Write burst beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Final write beat of the burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response accepted |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address accepted |
| araddr | output | ADDR_W | Read burst byte address |
| arlen | output | 8 | Read burst beats minus one |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data accepted |
| rdata | input | DATA_W | Read data |
| rlast | input | 1 | Final read beat of the burst |

## Verification
The assertions assume that the memory side keeps rvalid low except while a read burst the block requested is being returned, and that it returns exactly arlen+1 beats with rlast on the final one. They also assume each write burst receives one B response. They further assume input packets never exceed MAX_PKT beats and that in_valid, in_data and in_last stay stable until accepted. The bench's memory model returns R beats only for accepted ARs, keeps rvalid stable until rready, and answers each wlast with a single response. Its source keeps packet lengths between 1 and MAX_PKT and changes input beats only after a transfer.

// File: rtl/extmem_fifo_pkg.sv
package extmem_fifo_pkg;
  typedef enum logic [1:0] {WR_IDLE, WR_ADDR, WR_DATA, WR_RESP} wr_state_t;
  typedef enum logic [1:0] {RD_IDLE, RD_ADDR, RD_DATA} rd_state_t;
endpackage

// File: rtl/extmem_fifo_q.sv
module extmem_fifo_q #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp, wp_nx, rp_nx;
  logic [PW:0]   cnt, cnt_nx;

  always_comb begin
    wp_nx  = wp;
    rp_nx  = rp;
    cnt_nx = cnt;
    if (push) wp_nx = (wp == LAST_SLOT) ? '0 : wp + 1'b1;
    if (pop)  rp_nx = (rp == LAST_SLOT) ? '0 : rp + 1'b1;
    if (push && !pop) cnt_nx = cnt + 1'b1;
    if (pop && !push) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_nx;
      rp  <= rp_nx;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/extmem_fifo_wr.sv
module extmem_fifo_wr
  import extmem_fifo_pkg::*;
#(
  parameter int          ADDR_W       = 28,
  parameter int          DATA_W       = 64,
  parameter int          LEN_W        = 6,
  parameter int          BL_W         = 9,
  parameter int          OCC_W        = 7,
  parameter int          MAX_BURST    = 256,
  parameter logic [31:0] REGION_BASE  = 32'h0000_0FC0,
  parameter int          REGION_BYTES = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   len_empty,
  input  logic [LEN_W-1:0]       len_head,
  output logic                   len_pop,
  input  logic                   stage_empty,
  input  logic [DATA_W-1:0]      stage_head,
  output logic                   stage_pop,
  input  logic [OCC_W-1:0]       free_beats,
  input  logic                   job_full,
  output logic                   job_push,
  output logic [ADDR_W+BL_W:0]   job_din,
  output logic                   issue,
  output logic [BL_W-1:0]        issue_beats,
  output logic                   awvalid,
  input  logic                   awready,
  output logic [ADDR_W-1:0]      awaddr,
  output logic [7:0]             awlen,
  output logic                   wvalid,
  input  logic                   wready,
  output logic [DATA_W-1:0]      wdata,
  output logic                   wlast,
  input  logic                   bvalid,
  output logic                   bready
);
  localparam int          BYTES      = DATA_W / 8;
  localparam int          OFF_W      = $clog2(BYTES);
  localparam logic [31:0] REGION_END = REGION_BASE + 32'(REGION_BYTES);

  wr_state_t          st, st_nx;
  logic [ADDR_W-1:0]  addr, addr_nx, baddr, baddr_nx;
  logic [LEN_W-1:0]   rem, rem_nx;
  logic [BL_W-1:0]    blen, blen_nx, beat, beat_nx;
  logic [31:0]        c_4k, c_end, c_sel, a_next;

  // burst size: packet remainder, limited by burst cap, 4 KiB page and region end
  always_comb begin
    c_4k  = (32'd4096 - 32'(addr[11:0])) >> OFF_W;
    c_end = (REGION_END - 32'(addr)) >> OFF_W;
    c_sel = 32'(rem);
    if (c_sel > 32'(MAX_BURST)) c_sel = 32'(MAX_BURST);
    if (c_sel > c_4k)           c_sel = c_4k;
    if (c_sel > c_end)          c_sel = c_end;
    a_next = 32'(addr) + (c_sel << OFF_W);
    if (a_next == REGION_END) a_next = REGION_BASE;
  end

  assign issue_beats = BL_W'(c_sel);

  always_comb begin
    st_nx     = st;
    addr_nx   = addr;
    baddr_nx  = baddr;
    rem_nx    = rem;
    blen_nx   = blen;
    beat_nx   = beat;
    len_pop   = 1'b0;
    stage_pop = 1'b0;
    job_push  = 1'b0;
    issue     = 1'b0;
    unique case (st)
      WR_IDLE: begin
        if (rem == '0) begin
          if (!len_empty) begin
            len_pop = 1'b1;
            rem_nx  = len_head;
          end
        end else if (!job_full && (c_sel <= 32'(free_beats))) begin
          issue    = 1'b1;
          baddr_nx = addr;
          blen_nx  = issue_beats;
          rem_nx   = rem - LEN_W'(c_sel);
          addr_nx  = ADDR_W'(a_next);
          beat_nx  = '0;
          st_nx    = WR_ADDR;
        end
      end
      WR_ADDR: if (awready) st_nx = WR_DATA;
      WR_DATA: begin
        if (wvalid && wready) begin
          stage_pop = 1'b1;
          beat_nx   = beat + 1'b1;
          if (wlast) st_nx = WR_RESP;
        end
      end
      default: begin
        if (bvalid) begin
          job_push = 1'b1;
          st_nx    = WR_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WR_IDLE;
      addr  <= ADDR_W'(REGION_BASE);
      baddr <= '0;
      rem   <= '0;
      blen  <= '0;
      beat  <= '0;
    end else begin
      st    <= st_nx;
      addr  <= addr_nx;
      baddr <= baddr_nx;
      rem   <= rem_nx;
      blen  <= blen_nx;
      beat  <= beat_nx;
    end
  end

  assign awvalid = (st == WR_ADDR);
  assign awaddr  = baddr;
  assign awlen   = 8'(blen - 1'b1);
  assign wvalid  = (st == WR_DATA) && !stage_empty;
  assign wdata   = stage_head;
  assign wlast   = (beat == blen - 1'b1);
  assign bready  = (st == WR_RESP);
  assign job_din = {(rem == '0), blen, baddr};
endmodule

// File: rtl/extmem_fifo_rd.sv
module extmem_fifo_rd
  import extmem_fifo_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64,
  parameter int BL_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 job_empty,
  input  logic [ADDR_W+BL_W:0] job_dout,
  output logic                 job_pop,
  output logic                 beat_out,
  output logic                 arvalid,
  input  logic                 arready,
  output logic [ADDR_W-1:0]    araddr,
  output logic [7:0]           arlen,
  input  logic                 rvalid,
  output logic                 rready,
  input  logic [DATA_W-1:0]    rdata,
  input  logic                 rlast,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_last
);
  rd_state_t         st, st_nx;
  logic [ADDR_W-1:0] raddr, raddr_nx;
  logic [BL_W-1:0]   rlen, rlen_nx;
  logic              reop, reop_nx;

  always_comb begin
    st_nx    = st;
    raddr_nx = raddr;
    rlen_nx  = rlen;
    reop_nx  = reop;
    job_pop  = 1'b0;
    unique case (st)
      RD_IDLE: begin
        if (!job_empty) begin
          job_pop  = 1'b1;
          raddr_nx = job_dout[ADDR_W-1:0];
          rlen_nx  = job_dout[ADDR_W+BL_W-1:ADDR_W];
          reop_nx  = job_dout[ADDR_W+BL_W];
          st_nx    = RD_ADDR;
        end
      end
      RD_ADDR: if (arready) st_nx = RD_DATA;
      default: if (rvalid && out_ready && rlast) st_nx = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      raddr <= '0;
      rlen  <= '0;
      reop  <= 1'b0;
    end else begin
      st    <= st_nx;
      raddr <= raddr_nx;
      rlen  <= rlen_nx;
      reop  <= reop_nx;
    end
  end

  assign arvalid   = (st == RD_ADDR);
  assign araddr    = raddr;
  assign arlen     = 8'(rlen - 1'b1);
  assign out_valid = (st == RD_DATA) && rvalid;
  assign rready    = (st == RD_DATA) && out_ready;
  assign out_data  = rdata;
  assign out_last  = rlast && reop;
  assign beat_out  = out_valid && out_ready;
endmodule

// File: rtl/extmem_fifo.sv
module extmem_fifo #(
  parameter int          ADDR_W       = 28,
  parameter int          DATA_W       = 64,
  parameter int          MAX_BURST    = 256,
  parameter int          JOB_DEPTH    = 8,
  parameter int          STAGE_DEPTH  = 32,
  parameter int          MAX_PKT      = 32,
  parameter logic [31:0] REGION_BASE  = 32'h0000_0FC0,
  parameter int          REGION_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rlast
);
  localparam int REGION_BEATS = REGION_BYTES / (DATA_W / 8);
  localparam int LEN_W        = $clog2(MAX_PKT + 1);
  localparam int BL_W         = $clog2(MAX_BURST + 1);
  localparam int OCC_W        = $clog2(REGION_BEATS + 1);
  localparam int JOB_W        = ADDR_W + BL_W + 1;

  logic              rst_q1, srst_n;
  logic              stage_full, stage_empty, stage_pop;
  logic [DATA_W-1:0] stage_head;
  logic              len_full, len_empty, len_pop;
  logic [LEN_W-1:0]  len_head, pk_cnt, pk_cnt_nx;
  logic              in_fire;
  logic              job_full, job_empty, job_push, job_pop;
  logic [JOB_W-1:0]  job_din, job_dout;
  logic              issue, beat_out;
  logic [BL_W-1:0]   issue_beats;
  logic [OCC_W-1:0]  occ, occ_nx, free_beats;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      srst_n <= rst_q1;
    end
  end

  assign in_ready = !stage_full && !len_full;
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    pk_cnt_nx = pk_cnt;
    if (in_fire) pk_cnt_nx = in_last ? '0 : pk_cnt + 1'b1;
    occ_nx = occ;
    if (issue)    occ_nx = occ_nx + OCC_W'(issue_beats);
    if (beat_out) occ_nx = occ_nx - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pk_cnt <= '0;
      occ    <= '0;
    end else begin
      pk_cnt <= pk_cnt_nx;
      occ    <= occ_nx;
    end
  end

  assign free_beats = OCC_W'(REGION_BEATS) - occ;

  extmem_fifo_q #(.W(DATA_W), .DEPTH(STAGE_DEPTH)) u_stage (
    .clk(clk), .rst_n(srst_n), .push(in_fire), .pop(stage_pop),
    .din(in_data), .dout(stage_head), .full(stage_full), .empty(stage_empty));

  extmem_fifo_q #(.W(LEN_W), .DEPTH(STAGE_DEPTH)) u_len (
    .clk(clk), .rst_n(srst_n), .push(in_fire && in_last), .pop(len_pop),
    .din(pk_cnt + 1'b1), .dout(len_head), .full(len_full), .empty(len_empty));

  extmem_fifo_q #(.W(JOB_W), .DEPTH(JOB_DEPTH)) u_job (
    .clk(clk), .rst_n(srst_n), .push(job_push), .pop(job_pop),
    .din(job_din), .dout(job_dout), .full(job_full), .empty(job_empty));

  extmem_fifo_wr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BL_W(BL_W), .OCC_W(OCC_W),
    .MAX_BURST(MAX_BURST), .REGION_BASE(REGION_BASE), .REGION_BYTES(REGION_BYTES)
  ) u_wr (
    .clk(clk), .rst_n(srst_n),
    .len_empty(len_empty), .len_head(len_head), .len_pop(len_pop),
    .stage_empty(stage_empty), .stage_head(stage_head), .stage_pop(stage_pop),
    .free_beats(free_beats), .job_full(job_full), .job_push(job_push), .job_din(job_din),
    .issue(issue), .issue_beats(issue_beats),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
    .bvalid(bvalid), .bready(bready));

  extmem_fifo_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BL_W(BL_W)) u_rd (
    .clk(clk), .rst_n(srst_n),
    .job_empty(job_empty), .job_dout(job_dout), .job_pop(job_pop), .beat_out(beat_out),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rlast(rlast),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));
endmodule

// File: rtl/extmem_fifo_chk.sv
module extmem_fifo_chk #(
  parameter int          ADDR_W       = 28,
  parameter int          DATA_W       = 64,
  parameter int          MAX_BURST    = 256,
  parameter logic [31:0] REGION_BASE  = 32'h0000_0FC0,
  parameter int          REGION_BYTES = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic              wvalid,
  input logic              wready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready
);
  localparam int          OFF_W      = $clog2(DATA_W / 8);
  localparam logic [31:0] REGION_END = REGION_BASE + 32'(REGION_BYTES);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> in_ready && !awvalid && !wvalid && !arvalid && !out_valid);

  // R6
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  // R6
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
  // R6
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R3
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (32'(awaddr[11:0]) + ((32'(awlen) + 32'd1) << OFF_W) <= 32'd4096)
                && (32'(awlen) < 32'(MAX_BURST)));

  // R4
  aw_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awaddr[OFF_W-1:0] == '0) && (32'(awaddr) >= REGION_BASE)
                && (32'(awaddr) + ((32'(awlen) + 32'd1) << OFF_W) <= REGION_END));
  // R4
  ar_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (araddr[OFF_W-1:0] == '0) && (32'(araddr) >= REGION_BASE)
                && (32'(araddr) + ((32'(arlen) + 32'd1) << OFF_W) <= REGION_END));

  // R10
  r_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> out_valid && (rready == out_ready));
endmodule

bind extmem_fifo extmem_fifo_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST),
  .REGION_BASE(REGION_BASE), .REGION_BYTES(REGION_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
  .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
  .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
  .rvalid(rvalid), .rready(rready));

// File: tb/sim_extmem_fifo.sv
module sim_extmem_fifo;
  localparam int ADDR_W = 28, DATA_W = 64, MAX_BURST = 256, STAGE_DEPTH = 32, MAX_PKT = 32;
  localparam int BASE = 32'h0FC0, REGION_BYTES = 512, BYTES = DATA_W / 8;
  localparam int REGION_BEATS = REGION_BYTES / BYTES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0, rdata = '0;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0, arready = 1'b0;
  logic rvalid = 1'b0, rlast = 1'b0;
  logic in_ready, out_valid, out_last, awvalid, wvalid, wlast, bready, arvalid, rready;
  logic [DATA_W-1:0] out_data, wdata;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;

  always #4 clk = ~clk;

  extmem_fifo u0 (.*);

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  logic [DATA_W-1:0] mem [int];
  logic [DATA_W-1:0] src_d[$], exp_w[$], exp_od[$];
  bit src_l[$], exp_ol[$];
  int done_a[$], done_l[$];
  int unread = 0, waddr = 0, wlen = 0, wcnt = 0, prev_wlast = -100, pend_a = 0, pend_l = 0;
  int r_addr = 0, r_left = 0, splits = 0, hold_acc = 0;
  bit r_active = 0, r_taken = 0, in_taken = 0, b_pend = 0;
  bit aw_hold = 0, out_hold = 0, gaps = 0;
  int unsigned lcg = 32'h1234_5678, seq = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_pkt(input int len);
    for (int i = 0; i < len; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      seq++;
      src_d.push_back({seq, lcg});
      src_l.push_back(i == len - 1);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory slave, stream source and sink, reference bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        finish_run();
      end
      if (in_taken) begin in_valid = 1'b0; in_taken = 0; end
      if (r_taken) begin
        rvalid = 1'b0; r_taken = 0; r_left--; r_addr += BYTES;
        if (r_left == 0) r_active = 0;
      end
      if (!in_valid && src_d.size() > 0 && (!gaps || cyc % 4 != 0)) begin
        in_valid = 1'b1; in_data = src_d[0]; in_last = src_l[0];
      end
      if (!rvalid && r_active && (!gaps || cyc % 3 != 0)) begin
        rvalid = 1'b1; rdata = mem[r_addr / BYTES]; rlast = (r_left == 1);
      end
      awready = !aw_hold && (!gaps || cyc % 3 != 1);
      wready  = !gaps || cyc % 5 != 2;
      arready = !gaps || cyc % 4 != 2;
      out_ready = !out_hold && (!gaps || cyc % 7 != 3);
      bvalid = b_pend;
      #1;
      if (in_valid && in_ready) begin
        exp_w.push_back(src_d[0]); exp_od.push_back(src_d[0]); exp_ol.push_back(src_l[0]);
        void'(src_d.pop_front()); void'(src_l.pop_front());
        in_taken = 1;
        if (aw_hold) hold_acc++;
      end
      if (awvalid && awready) begin
        waddr = int'(awaddr); wlen = int'(awlen) + 1; wcnt = 0;
        // R3: page crossing and burst cap
        chk((waddr % 4096) + wlen * BYTES <= 4096 && wlen <= MAX_BURST, "R3", waddr, wlen);
        if ((waddr + wlen * BYTES) % 4096 == 0) splits++;
        // R4: alignment and region bounds
        chk(waddr % BYTES == 0 && waddr >= BASE && waddr + wlen * BYTES <= BASE + REGION_BYTES,
            "R4", waddr, BASE);
        // R8: capacity of the region
        chk(unread + wlen <= REGION_BEATS, "R8", unread + wlen, REGION_BEATS);
        unread += wlen;
      end
      if (wvalid && wready) begin
        if (wcnt == 0) chk(cyc - prev_wlast >= 3, "R9", cyc - prev_wlast, 3);
        chk(exp_w.size() > 0 && wdata == exp_w[0], "R2", wdata, exp_w.size() > 0 ? exp_w[0] : 0);
        if (exp_w.size() > 0) void'(exp_w.pop_front());
        // R7: wlast on the final beat only
        chk(wlast == (wcnt == wlen - 1), "R7", wlast, wcnt == wlen - 1);
        mem[(waddr + wcnt * BYTES) / BYTES] = wdata;
        wcnt++;
        if (wlast) begin
          prev_wlast = cyc; b_pend = 1; pend_a = waddr; pend_l = wlen;
        end
      end
      if (bvalid && bready) begin
        done_a.push_back(pend_a); done_l.push_back(pend_l); b_pend = 0;
      end
      if (arvalid && arready) begin
        // R5: AR follows completed writes in order
        chk(done_a.size() > 0 && int'(araddr) == done_a[0] && int'(arlen) + 1 == done_l[0],
            "R5", araddr, done_a.size() > 0 ? done_a[0] : -1);
        // R4: read address inside region
        chk(int'(araddr) >= BASE && int'(araddr) % BYTES == 0, "R4", araddr, BASE);
        if (done_a.size() > 0) begin
          r_addr = done_a.pop_front(); r_left = done_l.pop_front(); r_active = 1;
        end
      end
      if (rvalid) begin
        // R10: output and R channel move together
        chk(out_valid && rready == out_ready && out_data == rdata, "R10", out_valid, 1);
      end
      if (rvalid && rready) r_taken = 1;
      if (out_valid && out_ready) begin
        chk(exp_od.size() > 0 && out_data == exp_od[0] && out_last == exp_ol[0], "R2",
            out_data, exp_od.size() > 0 ? exp_od[0] : 0);
        if (exp_od.size() > 0) begin void'(exp_od.pop_front()); void'(exp_ol.pop_front()); end
        unread--;
      end
    end
  end

  task automatic drain();
    while (src_d.size() > 0 || exp_od.size() > 0) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    chk(!awvalid && !wvalid && !arvalid && !out_valid, "R1", {awvalid, wvalid, arvalid, out_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1: idle outputs after release
    chk(in_ready && !awvalid && !wvalid && !arvalid && !out_valid, "R1", in_ready, 1);

    // R2: plain traffic of assorted lengths
    add_pkt(1); add_pkt(2); add_pkt(3); add_pkt(8); add_pkt(MAX_PKT);
    drain();

    // R2 R6 R9: gaps on every channel
    gaps = 1;
    for (int i = 0; i < 25; i++) add_pkt(1 + int'(lcg % MAX_PKT));
    drain();
    gaps = 0;

    // R11: write path blocked, staging queue fills
    @(posedge clk);
    aw_hold = 1; hold_acc = 0;
    for (int i = 0; i < 12; i++) add_pkt(4);
    repeat (120) @(negedge clk);
    #2;
    chk(hold_acc == STAGE_DEPTH, "R11", hold_acc, STAGE_DEPTH);
    chk(!in_ready, "R11", in_ready, 0);
    aw_hold = 0;
    drain();

    // R8: output blocked, region fills and writes stop
    out_hold = 1;
    for (int i = 0; i < 10; i++) add_pkt(20);
    repeat (400) @(negedge clk);
    #2;
    chk(unread <= REGION_BEATS && unread > REGION_BEATS / 2, "R8", unread, REGION_BEATS);
    out_hold = 0;
    drain();

    chk(exp_w.size() == 0 && done_a.size() == 0 && unread == 0, "R2", unread, 0);
    // R3: page boundary splits occurred
    chk(splits > 0, "R3", splits, 1);
    finish_run();
  end
endmodule